// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave for a two-wire bus. An external master uses it to read and write a small bank of 8-bit control registers. The block samples SCL and SDA with a fast system clock and detects START, repeated START and STOP conditions. It answers only to its own 7-bit address, 69h. The address byte is therefore D2h for a write and D3h for a read. SDA is driven open-drain: the block either pulls the line low or releases it.

The first byte after a write address is a command byte. When bit 7 of the command is set, the transfer is a single indexed access, and bits 6:0 give the register offset. When bit 7 is clear, the transfer is a block access. A block access always starts at register 0 and carries a byte count. On a block write, the master sends the count. On a block read, the slave sends the count. Data moves most significant bit first.

There are two registers. Register 0 holds the drive-strength select for the PCI outputs in bit 6. Its bits 4:0 mirror five strap inputs that are latched outside the block. Register 1 holds the output enables for three differential clock pairs in bits 2:0. The other bits of both registers are fixed.

Top module: `smb_reg_slave`

## Requirements
- R1: The block acknowledges only the address byte D2h (write) or D3h (read). After any other address byte, it keeps SDA released for the rest of the transaction and changes no register.
- R2: During a write, the block acknowledges each accepted byte (address, command, count and data) by holding SDA low through the ninth SCL pulse.
- R3: A write command byte with bit 7 = 1 selects the register at offset bits 6:0. The next data byte is written to that register.
- R4: An indexed read returns one byte. The sequence is: address D2h, command with bit 7 = 1 and the offset, repeated START, address D3h. The byte returned is the register at that offset, MSB first. Offsets of 2 and above read as 00h.
- R5: A block write is address D2h, command 00h, a count byte, then data bytes. The data bytes land in register 0, then register 1, in ascending order. Data for offsets of 2 and above is discarded. A STOP after any complete byte ends the transfer, and the bytes already received are kept.
- R6: A block read is address D2h, command 00h, repeated START, address D3h. The block then sends the count 02h, then register 0, then register 1, then 00h for as long as the master keeps acknowledging. A NACK from the master ends the transmission and releases SDA.
- R7: While reset is asserted, register 1 loads 7Fh and the register 0 drive bit loads 1. After reset, SDA is released.
- R8: Some bits are read-only and ignore writes. Register 0 bits 7 and 5 read 0. Register 0 bits 4:0 show `strap_i` as it was one clock earlier. Register 1 bit 7 reads 0, and register 1 bits 6:3 read 1.
- R9: `clk_oe_o` equals register 1 bits 2:0, where 1 means enabled and 0 means three-state. `pci_drive_hi_o` equals register 0 bit 6, where 1 means high drive.
- R10: The SDA drive and the writable register bits change only while SCL is low.
- R11: A repeated START at any point, including in the middle of a byte, starts a new address phase, and the partial byte is dropped. A STOP at any point returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 5 | Externally latched strap values |
| cfg0_o | output | 8 | Register 0 contents |
| cfg1_o | output | 8 | Register 1 contents |
| clk_oe_o | output | 3 | Output enables for the three clock pairs |
| pci_drive_hi_o | output | 1 | High drive strength select for PCI outputs |

## Verification
The hardest case to reach from the pins is a repeated START that arrives partway through a data byte. The slave has shifted in some bits but has not yet acted on them, and it must discard them without touching any register. The stimulus reaches this case by sending four data bits, raising SDA while SCL is low, and then generating a START. A full indexed write follows. The register outputs must show only that later write. A read sequence that runs past the last register and ends with a NACK covers the zero-fill and the release of SDA.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  localparam int NUM_REGS = 2;
  localparam int DW       = 8;
  localparam int OFFW     = 7;
  localparam int STRAP_W  = 5;
  localparam int OE_W     = 3;
  localparam logic [6:0] DEV_ADDR_DEF = 7'h69;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    ROLE_ADDR, ROLE_CMD, ROLE_CNT, ROLE_DATA
  } smb_role_e;

  // Bits the master may change.
  function automatic logic [DW-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // Power-up values of the writable bits.
  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // Constant read-only bits.
  function automatic logic [DW-1:0] reg_fixed(input int idx);
    case (idx)
      1:       return 8'h78;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that show the strap inputs.
  function automatic logic [DW-1:0] reg_strap_mask(input int idx);
    case (idx)
      0:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      scl_p  <= 1'b1;
      sda_q  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        scl_ff[k] <= scl_ff[k-1];
        sda_ff[k] <= sda_ff[k-1];
      end
      scl_q <= scl_ff[SYNC_STAGES-1];
      sda_q <= sda_ff[SYNC_STAGES-1];
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign sda_s     = sda_q;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_reg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [OFFW-1:0]                ptr,
  input  logic [DW-1:0]                  wr_data,
  input  logic [STRAP_W-1:0]             strap_i,
  output logic [DW-1:0]                  rd_data,
  output logic [NUM_REGS-1:0][DW-1:0]    regs_o
);
  logic [STRAP_W-1:0] strap_q;
  logic [DW-1:0]      strap_ext;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= '0;
    else     strap_q <= strap_i;
  end

  assign strap_ext = {{(DW-STRAP_W){1'b0}}, strap_q};

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= reg_default(gi) & reg_wmask(gi);
      else if (wr_en && ptr == OFFW'(gi))
        q <= wr_data & reg_wmask(gi);
    end
    assign regs_o[gi] = q | reg_fixed(gi) | (strap_ext & reg_strap_mask(gi));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == OFFW'(i)) rd_data = regs_o[i];
  end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [DW-1:0]   rd_data,
  output logic [OFFW-1:0] ptr_o,
  output logic            wr_en,
  output logic [DW-1:0]   wr_data,
  output logic            sda_low_o
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  smb_state_e      st;
  smb_role_e       role;
  logic [3:0]      bitcnt;
  logic [DW-1:0]   shreg;
  logic [OFFW-1:0] ptr;
  logic            blk, rnw, mack;
  logic            byte_end;

  assign byte_end = scl_fall && (bitcnt == BYTE_BITS);
  assign wr_en    = (st == S_RX) && byte_end && (role == ROLE_DATA);
  assign wr_data  = shreg;
  assign ptr_o    = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      role      <= ROLE_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      blk       <= 1'b0;
      rnw       <= 1'b0;
      mack      <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      sda_low_o <= (st == S_RX_ACK) || (st == S_TX && !shreg[DW-1]);
      if (start_det) begin
        st     <= S_RX;
        role   <= ROLE_ADDR;
        bitcnt <= '0;
      end else if (stop_det) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != BYTE_BITS) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              case (role)
                ROLE_ADDR: begin
                  if (shreg[DW-1:1] == DEV_ADDR) begin
                    rnw <= shreg[0];
                    st  <= S_RX_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                ROLE_CMD: begin
                  blk <= ~shreg[DW-1];
                  ptr <= shreg[DW-1] ? shreg[OFFW-1:0] : '0;
                  st  <= S_RX_ACK;
                end
                ROLE_CNT: st <= S_RX_ACK;
                default: begin
                  ptr <= ptr + 7'd1;
                  st  <= S_RX_ACK;
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (role == ROLE_ADDR && rnw) begin
                st <= S_TX;
                if (blk) begin
                  shreg <= DW'(NUM_REGS);
                end else begin
                  shreg <= rd_data;
                  ptr   <= ptr + 7'd1;
                end
              end else begin
                st <= S_RX;
                case (role)
                  ROLE_ADDR: role <= ROLE_CMD;
                  ROLE_CMD:  role <= blk ? ROLE_CNT : ROLE_DATA;
                  default:   role <= ROLE_DATA;
                endcase
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == BYTE_BITS) st <= S_TX_ACK;
              else                     shreg <= {shreg[DW-2:0], 1'b0};
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= S_TX;
                shreg  <= rd_data;
                ptr    <= ptr + 7'd1;
                bitcnt <= '0;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_low_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [DW-1:0]      cfg0_o,
  output logic [DW-1:0]      cfg1_o,
  output logic [OE_W-1:0]    clk_oe_o,
  output logic               pci_drive_hi_o
);
  logic                        sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [OFFW-1:0]             ptr;
  logic                        wr_en;
  logic [DW-1:0]               wr_data, rd_data;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr_o(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_low_o(sda_low_o)
  );

  smb_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .strap_i(strap_i), .rd_data(rd_data), .regs_o(regs)
  );

  assign cfg0_o         = regs[0];
  assign cfg1_o         = regs[1];
  assign clk_oe_o       = regs[1][OE_W-1:0];
  assign pci_drive_hi_o = regs[0][6];
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_low_o,
  input logic [4:0] strap_i,
  input logic [7:0] cfg0_o,
  input logic [7:0] cfg1_o,
  input logic       pci_drive_hi_o
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg1_o == 8'h7F) && pci_drive_hi_o && !sda_low_o); // R7

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    !cfg0_o[7] && !cfg0_o[5] && (cfg1_o[7:3] == 5'b01111)); // R8

  AST_STRAP_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cfg0_o[4:0] == $past(strap_i)); // R8

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low_o) |-> !scl_i); // R10

  AST_CFG_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg1_o) || !$stable(pci_drive_hi_o) |-> !scl_i); // R10
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .strap_i(strap_i), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o),
  .pci_drive_hi_o(pci_drive_hi_o)
);

// File: tb/tb_smb_reg_slave.sv
`timescale 1ns/1ps
module tb_smb_reg_slave;
  localparam int Q = 8;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'h15;
  logic sda_line, sda_low, drv_hi;
  logic [7:0] cfg0, cfg1;
  logic [2:0] oe;

  assign sda_line = sda_m & ~sda_low;
  always #4 clk = ~clk;

  smb_reg_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_low_o(sda_low),
    .strap_i(strap), .cfg0_o(cfg0), .cfg1_o(cfg1), .clk_oe_o(oe),
    .pci_drive_hi_o(drv_hi)
  );

  int checks = 0, errs = 0;
  bit done = 0, live = 0, quiet = 0;

  // behavioural model
  logic [2:0] m_oe  = 3'b111;
  logic       m_drv = 1'b1;
  logic [4:0] m_strap = '0;
  always @(posedge clk) m_strap <= strap;

  function automatic logic [7:0] exp_reg(input int off);
    if (off == 0) return {1'b0, m_drv, 1'b0, m_strap};
    if (off == 1) return {1'b0, 4'hF, m_oe};
    return 8'h00;
  endfunction

  function automatic void apply_write(input int off, input logic [7:0] d);
    if (off == 0) m_drv = d[6];
    if (off == 1) m_oe  = d[2:0];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is idle (R7 R8 R9)
  always @(negedge clk) begin
    if (!rst && live) begin
      checks++;
      if (cfg0 !== exp_reg(0) || cfg1 !== exp_reg(1) || oe !== m_oe ||
          drv_hi !== m_drv || sda_low !== 1'b0) begin
        errs++;
        $display("FAIL R8/R9 idle compare: actual %02h %02h %0b %0b %0b expected %02h %02h %0b %0b 0",
                 cfg0, cfg1, oe, drv_hi, sda_low, exp_reg(0), exp_reg(1), m_oe, m_drv);
      end
    end
    if (quiet) begin
      checks++;
      if (sda_low !== 1'b0) begin
        errs++;
        $display("FAIL R1 foreign address: actual sda_low=%0b expected 0", sda_low);
      end
    end
  end

  // R10: SDA drive may only change while SCL is low
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_low !== prev_low) begin
      checks++;
      if (scl !== 1'b0) begin
        errs++;
        $display("FAIL R10 drive change: actual scl=%0b expected 0", scl);
      end
    end
    prev_low <= sda_low;
  end

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wait_q(); scl = 1'b1; wait_q(); s = sda_line; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic rx(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(!give_ack, s);
  endtask

  task automatic begin_tx(); live = 0; bus_start(); endtask
  task automatic end_tx(); bus_stop(); repeat (4) @(negedge clk); live = 1; endtask

  task automatic wr_one(input int off, input logic [7:0] d);
    logic a;
    begin_tx();
    tx(8'hD2, a);                  chk("R2 address ack", {7'd0, a}, 8'd1);
    tx({1'b1, 7'(off)}, a);        chk("R2 command ack", {7'd0, a}, 8'd1);
    tx(d, a);                      chk("R3 data ack", {7'd0, a}, 8'd1);
    apply_write(off, d);
    end_tx();
  endtask

  task automatic rd_one(input int off);
    logic a; logic [7:0] b;
    begin_tx();
    tx(8'hD2, a);
    tx({1'b1, 7'(off)}, a);
    bus_start();
    tx(8'hD3, a);                  chk("R4 read address ack", {7'd0, a}, 8'd1);
    rx(1'b0, b);                   chk("R4 indexed read", b, exp_reg(off));
    end_tx();
  endtask

  task automatic blk_wr(input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a; logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    begin_tx();
    tx(8'hD2, a);
    tx(8'h00, a);                  chk("R5 block command ack", {7'd0, a}, 8'd1);
    tx(8'(n), a);                  chk("R5 count ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      tx(d[k], a);                 chk("R5 block data ack", {7'd0, a}, 8'd1);
      apply_write(k, d[k]);
    end
    end_tx();
  endtask

  task automatic blk_rd(input int n);
    logic a; logic [7:0] b;
    begin_tx();
    tx(8'hD2, a);
    tx(8'h00, a);
    bus_start();
    tx(8'hD3, a);                  chk("R6 read address ack", {7'd0, a}, 8'd1);
    rx(n > 0, b);                  chk("R6 byte count", b, 8'h02);
    for (int k = 0; k < n; k++) begin
      rx(k < n - 1, b);            chk("R6 block data", b, exp_reg(k));
    end
    end_tx();
  endtask

  initial begin
    logic a; logic s;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    chk("R7 reg0 default", cfg0, 8'h55);
    chk("R7 reg1 default", cfg1, 8'h7F);
    chk("R9 enables default", {5'd0, oe}, 8'h07);
    chk("R7 sda released", {7'd0, sda_low}, 8'h00);
    live = 1;
    repeat (10) @(negedge clk);

    // R3 R8 R9: indexed writes, read-only bits ignored
    wr_one(1, 8'h05);
    chk("R8 reg1 after write 05h", cfg1, 8'h7D);
    chk("R9 enables", {5'd0, oe}, 8'h05);
    wr_one(0, 8'h00);
    chk("R9 drive low", {7'd0, drv_hi}, 8'h00);
    wr_one(0, 8'hFF);
    chk("R8 reg0 after write FFh", cfg0, 8'h55);

    // R4 indexed reads
    rd_one(0);
    rd_one(1);
    rd_one(5);

    // R5 block writes, full, extra byte and early stop
    blk_wr(2, 8'h00, 8'h02, 8'h00);
    chk("R5 block write reg1", cfg1, 8'h7A);
    blk_wr(3, 8'h40, 8'h06, 8'hFF);
    chk("R5 third byte discarded", cfg1, 8'h7E);
    blk_wr(0, 8'h00, 8'h00, 8'h00);
    blk_wr(1, 8'h00, 8'h00, 8'h00);
    chk("R5 partial block keeps reg1", cfg1, 8'h7E);

    // R6 block reads
    blk_rd(4);
    blk_rd(0);
    blk_rd(1);

    // R1 foreign address is ignored
    begin_tx();
    quiet = 1;
    tx(8'hA4, a);                  chk("R1 no ack for A4h", {7'd0, a}, 8'h00);
    tx(8'h81, a);
    tx(8'h00, a);
    quiet = 0;
    end_tx();
    chk("R1 reg1 untouched", cfg1, 8'h7E);

    // R8 strap mirror
    strap = 5'h0A;
    repeat (3) @(negedge clk);
    chk("R8 strap mirror", cfg0, {1'b0, m_drv, 1'b0, 5'h0A});

    // R11 repeated START in the middle of a data byte
    begin_tx();
    tx(8'hD2, a);
    tx(8'h81, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    bus_start();
    tx(8'hD2, a);                  chk("R11 address after restart", {7'd0, a}, 8'd1);
    tx(8'h81, a);
    tx(8'h03, a);
    apply_write(1, 8'h03);
    end_tx();
    chk("R11 only full byte written", cfg1, 8'h7B);

    // R11 STOP in the middle of a data byte
    begin_tx();
    tx(8'hD2, a);
    tx(8'h80, a);
    for (int i = 0; i < 3; i++) bit_io(1'b0, s);
    end_tx();
    chk("R11 stop drops partial byte", cfg0, {1'b0, m_drv, 1'b0, 5'h0A});
    rd_one(0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule